// File: doc/BRIEF.md
# Seven-slot serial-to-parallel lane receiver

This block rebuilds wide parallel words from a narrow serial link. The serializer at the far end sends four data lanes and a forwarded clock lane. It places seven bit slots on every lane in each word period. The receiver runs on a bit-rate clock supplied by its environment and shifts one slot per lane on every bit clock. It watches the clock lane for the fixed seven-slot framing mark, and from that mark it finds where each word starts and ends.

Once the framing mark has appeared at the correct spacing for three words in a row, the receiver declares lock. It then publishes one 28-bit word per word period, with a one-cycle valid pulse and a word-rate output clock that it derives by counting bit clocks from the framed boundary. The outputs hold zero until lock is reached and again after lock is lost. A power-down input forces every output low at once and empties all internal state, so lock has to be earned again afterwards.

Top module: `slot7_deserializer`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, `wordOut`, `wordValid`, `wordClk` and `locked` are all low.
- R2: A word boundary is seen on the bit clock where the last seven clock-lane slots, taken in arrival order, read 1,1,0,0,0,1,1. A boundary is correctly spaced when it comes exactly seven bit clocks after the previous one.
- R3: Within a word, the slot that arrives j-th on a lane (j = 0 to 6, slot 0 first) of lane k (k = 0 to 3) lands on bit 7k+j of `wordOut`.
- R4: `locked` rises after the edge that acts on the third correctly spaced boundary in a row. The first boundary seen counts as one.
- R5: If no boundary appears at the cycle where one is expected, `locked` and `wordOut` go to zero after that edge. A boundary that arrives out of step also drops lock and restarts the count at one.
- R6: Once the receiver is locked, a word appears on `wordOut` after the edge that samples slot 0 of the second word that follows it. That is two word periods after its own slot 0.
- R7: `wordValid` is high for exactly one bit-clock cycle each time a new word is published, and only while the receiver is locked.
- R8: While the receiver is locked, `wordClk` is low for the first three bit-clock cycles of each word period and high for the remaining four, so it rises mid-word. It is low whenever the receiver is unlocked.
- R9: Before lock is reached, `wordOut` is zero and `wordValid` is low.
- R10: While `powerDown` is high, all outputs are low in the same cycle. All state is cleared, so after release three new correctly spaced boundaries are needed to lock again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Bit-rate clock, one slot per edge |
| rstN | input | 1 | Asynchronous active-low reset |
| powerDown | input | 1 | Forces outputs low and clears state |
| laneIn | input | 4 | Serial data lanes, bit k is lane k |
| clkLaneIn | input | 1 | Forwarded clock lane carrying the framing mark |
| wordOut | output | 28 | Rebuilt parallel word |
| wordValid | output | 1 | One-cycle strobe per published word |
| wordClk | output | 1 | Word-rate output clock, 4 high / 3 low |
| locked | output | 1 | Framing lock indication |

## Verification
The hardest situation to reach from the ports is losing and regaining lock in mid-stream. This happens when a frame carries a damaged clock-lane mark, when the stream slips by one bit clock, and when power-down is raised while the receiver is locked. The stimulus builds each of these from the clock-lane pattern alone: it sends a corrupted mark, inserts one extra idle slot, or pulses power-down. It then sends three clean frames, and a behavioural model that tracks the boundary spacing predicts when lock drops and when it comes back.

// File: rtl/slot7_pkg.sv
package slot7_pkg;
  localparam int unsigned DEF_LANES      = 4;
  localparam int unsigned DEF_SLOTS      = 7;
  localparam int unsigned DEF_LOCK_WORDS = 3;
  localparam logic [DEF_SLOTS-1:0] DEF_FRAME_MARK = 7'b1100011;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // load assembled word into the capture stage
    logic publish;    // move capture stage to the output word
    logic clearWord;  // force output word to zero
    logic flush;      // empty every shift register
  } deserStrobe_t;
endpackage

// File: rtl/slot7_datapath.sv
module slot7_datapath
  import slot7_pkg::*;
#(
  parameter int unsigned LANES = DEF_LANES,
  parameter int unsigned SLOTS = DEF_SLOTS,
  parameter logic [SLOTS-1:0] FRAME_MARK = DEF_FRAME_MARK,
  localparam int unsigned WORD_W = LANES * SLOTS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LANES-1:0]  laneIn,
  input  logic              clkLaneIn,
  input  deserStrobe_t      strobe,
  output logic              matchHit,
  output logic [WORD_W-1:0] wordReg
);

  logic [LANES-1:0][SLOTS-1:0] laneSr;
  logic [SLOTS-1:0]            clkSr;
  logic [WORD_W-1:0]           assembled;
  logic [WORD_W-1:0]           captureReg;

  // shift stage: newest slot enters at bit 0, oldest sits at the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laneSr <= '0;
      clkSr  <= '0;
    end else if (strobe.flush) begin
      laneSr <= '0;
      clkSr  <= '0;
    end else begin
      for (int k = 0; k < LANES; k++) begin
        laneSr[k] <= {laneSr[k][SLOTS-2:0], laneIn[k]};
      end
      clkSr <= {clkSr[SLOTS-2:0], clkLaneIn};
    end
  end

  assign matchHit = (clkSr == FRAME_MARK);

  // slot j of lane k (j-th to arrive) maps to word bit k*SLOTS+j
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    for (genvar j = 0; j < SLOTS; j++) begin : g_slot
      assign assembled[k*SLOTS+j] = laneSr[k][SLOTS-1-j];
    end
  end

  // two word stages: capture at each boundary, publish one boundary later
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      captureReg <= '0;
      wordReg    <= '0;
    end else begin
      if (strobe.flush) begin
        captureReg <= '0;
      end else if (strobe.capture) begin
        captureReg <= assembled;
      end
      if (strobe.clearWord) begin
        wordReg <= '0;
      end else if (strobe.publish) begin
        wordReg <= captureReg;
      end
    end
  end

endmodule

// File: rtl/slot7_control.sv
module slot7_control
  import slot7_pkg::*;
#(
  parameter int unsigned SLOTS      = DEF_SLOTS,
  parameter int unsigned LOCK_WORDS = DEF_LOCK_WORDS,
  localparam int unsigned PHASE_W   = $clog2(SLOTS),
  localparam int unsigned CNT_W     = $clog2(LOCK_WORDS + 1),
  localparam int unsigned HIGH_LEN  = (SLOTS + 1) / 2,
  localparam int unsigned HIGH_FROM = SLOTS - HIGH_LEN
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         powerDown,
  input  logic         matchHit,
  output deserStrobe_t strobe,
  output logic         lockedReg,
  output logic         validReg,
  output logic         clkRaw
);

  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(SLOTS - 1);
  localparam logic [PHASE_W-1:0] HIGH_PH    = PHASE_W'(HIGH_FROM);
  localparam logic [CNT_W-1:0]   LOCK_VAL   = CNT_W'(LOCK_WORDS);
  localparam logic [CNT_W-1:0]   ONE_VAL    = CNT_W'(1);

  logic [PHASE_W-1:0] phase, phaseNext;
  logic [CNT_W-1:0]   goodCnt, cntNext;
  logic               frameSeen, seenNext;
  logic               expectEdge, goodEdge, missEdge, lockNext;

  always_comb begin
    expectEdge = frameSeen && (phase == LAST_PHASE);
    goodEdge   = matchHit && expectEdge;
    missEdge   = !matchHit && expectEdge;
    cntNext    = goodCnt;
    seenNext   = frameSeen;
    phaseNext  = phase;
    if (matchHit) begin
      cntNext   = goodEdge ? ((goodCnt == LOCK_VAL) ? goodCnt : goodCnt + ONE_VAL) : ONE_VAL;
      seenNext  = 1'b1;
      phaseNext = '0;
    end else if (missEdge) begin
      cntNext   = '0;
      seenNext  = 1'b0;
      phaseNext = '0;
    end else if (frameSeen) begin
      phaseNext = phase + PHASE_W'(1);
    end
    lockNext = (cntNext == LOCK_VAL);
  end

  always_comb begin
    strobe.capture   = matchHit && !powerDown;
    strobe.publish   = matchHit && lockNext && !powerDown;
    strobe.clearWord = powerDown || !lockNext;
    strobe.flush     = powerDown;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= '0;
      goodCnt   <= '0;
      frameSeen <= 1'b0;
      lockedReg <= 1'b0;
      validReg  <= 1'b0;
    end else if (powerDown) begin
      phase     <= '0;
      goodCnt   <= '0;
      frameSeen <= 1'b0;
      lockedReg <= 1'b0;
      validReg  <= 1'b0;
    end else begin
      phase     <= phaseNext;
      goodCnt   <= cntNext;
      frameSeen <= seenNext;
      lockedReg <= lockNext;
      validReg  <= matchHit && lockNext;
    end
  end

  assign clkRaw = lockedReg && (phase >= HIGH_PH);

  // R4: lock can only appear on the edge acting on a boundary
  a_r4_lock_on_boundary: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockedReg) |-> $past(matchHit));

  // R5: a missing boundary at the expected cycle drops lock
  a_r5_miss_drops_lock: assert property (@(posedge clk) disable iff (!rstN)
    (frameSeen && phase == LAST_PHASE && !matchHit) |=> !lockedReg);

  // R5: an out-of-step boundary restarts the run at one
  a_r5_slip_restarts: assert property (@(posedge clk) disable iff (!rstN)
    (matchHit && !powerDown && !(frameSeen && phase == LAST_PHASE)) |=> (goodCnt == ONE_VAL));

  // R7: valid only while locked
  a_r7_valid_when_locked: assert property (@(posedge clk) disable iff (!rstN)
    validReg |-> lockedReg);

  // R10: power-down empties the control state
  a_r10_pd_clears: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> (!lockedReg && goodCnt == '0 && !frameSeen));

endmodule

// File: rtl/slot7_deserializer.sv
module slot7_deserializer
  import slot7_pkg::*;
#(
  parameter int unsigned LANES      = DEF_LANES,
  parameter int unsigned SLOTS      = DEF_SLOTS,
  parameter int unsigned LOCK_WORDS = DEF_LOCK_WORDS,
  parameter logic [SLOTS-1:0] FRAME_MARK = DEF_FRAME_MARK,
  localparam int unsigned WORD_W = LANES * SLOTS
) (
  input  logic              bitClk,
  input  logic              rstN,
  input  logic              powerDown,
  input  logic [LANES-1:0]  laneIn,
  input  logic              clkLaneIn,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid,
  output logic              wordClk,
  output logic              locked
);

  deserStrobe_t      strobe;
  logic              matchHit;
  logic [WORD_W-1:0] wordReg;
  logic              lockedReg, validReg, clkRaw;

  slot7_datapath #(
    .LANES(LANES), .SLOTS(SLOTS), .FRAME_MARK(FRAME_MARK)
  ) datapath_i (
    .clk(bitClk), .rstN(rstN), .laneIn(laneIn), .clkLaneIn(clkLaneIn),
    .strobe(strobe), .matchHit(matchHit), .wordReg(wordReg)
  );

  slot7_control #(
    .SLOTS(SLOTS), .LOCK_WORDS(LOCK_WORDS)
  ) control_i (
    .clk(bitClk), .rstN(rstN), .powerDown(powerDown), .matchHit(matchHit),
    .strobe(strobe), .lockedReg(lockedReg), .validReg(validReg), .clkRaw(clkRaw)
  );

  // power-down forces every output low in the same cycle
  assign wordOut   = powerDown ? '0 : wordReg;
  assign wordValid = validReg && !powerDown;
  assign wordClk   = clkRaw && !powerDown;
  assign locked    = lockedReg && !powerDown;

  // R9: the word register holds zero whenever control reports no lock
  a_r9_zero_unlocked: assert property (@(posedge bitClk) disable iff (!rstN)
    !lockedReg |-> (wordReg == '0));

  // R6: a new word is published only on the edge after a boundary
  a_r6_valid_after_match: assert property (@(posedge bitClk) disable iff (!rstN)
    validReg |-> $past(matchHit));

  // R8: output clock stays low when unlocked
  a_r8_clk_low_unlocked: assert property (@(posedge bitClk) disable iff (!rstN)
    !lockedReg |-> !clkRaw);

endmodule

// File: tb/slot7_deserializer_tb_top.sv
`timescale 1ns/1ps
module slot7_deserializer_tb_top;

  localparam logic [6:0] MARK = 7'b1100011;
  localparam logic [6:0] BAD  = 7'b1100111;

  logic        bitClk = 1'b0;
  logic        rstN = 1'b0;
  logic        powerDown = 1'b0;
  logic [3:0]  laneIn = '0;
  logic        clkLaneIn = 1'b0;
  logic [27:0] wordOut;
  logic        wordValid, wordClk, locked;

  int tests = 0;
  int fails = 0;
  int clkHighCnt = 0;

  always #10 bitClk = ~bitClk;

  slot7_deserializer dut_i (
    .bitClk(bitClk), .rstN(rstN), .powerDown(powerDown), .laneIn(laneIn),
    .clkLaneIn(clkLaneIn), .wordOut(wordOut), .wordValid(wordValid),
    .wordClk(wordClk), .locked(locked)
  );

  // behavioural reference
  bit          clkQ[$];
  bit          laneQ[4][$];
  int          mPhase = 0, mGood = 0;
  bit          mSeen = 0, mLocked = 0, mValid = 0, mPd = 0;
  logic [27:0] mCap = '0, mPub = '0;

  task automatic check(input string tag, input string what, input logic [27:0] act, input logic [27:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelStep(input bit pd, input logic [3:0] ln, input bit cb);
    bit hit, expectB, pub;
    logic [27:0] fresh;
    mPd = pd;
    if (pd) begin
      clkQ.delete();
      for (int k = 0; k < 4; k++) laneQ[k].delete();
      mPhase = 0; mGood = 0; mSeen = 0; mLocked = 0; mValid = 0; mCap = '0; mPub = '0;
      return;
    end
    hit = (clkQ.size() == 7);
    fresh = '0;
    if (hit) begin
      for (int j = 0; j < 7; j++) if (clkQ[j] != MARK[6-j]) hit = 0;
      for (int k = 0; k < 4; k++)
        for (int j = 0; j < 7; j++) fresh[7*k+j] = laneQ[k][j];
    end
    expectB = mSeen && (mPhase == 6);
    pub = 0;
    if (hit) begin
      mGood = expectB ? ((mGood < 3) ? mGood + 1 : 3) : 1;
      mSeen = 1; mPhase = 0;
      if (mGood == 3) begin mPub = mCap; pub = 1; end
      mCap = fresh;
    end else if (expectB) begin
      mGood = 0; mSeen = 0; mPhase = 0;
    end else if (mSeen) begin
      mPhase++;
    end
    mLocked = (mGood == 3);
    if (!mLocked) mPub = '0;
    mValid = pub;
    clkQ.push_back(cb);
    if (clkQ.size() > 7) void'(clkQ.pop_front());
    for (int k = 0; k < 4; k++) begin
      laneQ[k].push_back(ln[k]);
      if (laneQ[k].size() > 7) void'(laneQ[k].pop_front());
    end
  endtask

  task automatic compareAll();
    logic expClk;
    expClk = !mPd && mLocked && (mPhase >= 3);
    check("R3", "wordOut vs model", wordOut, mPd ? 28'h0 : mPub);
    check("R4", "locked vs model", {27'h0, locked}, {27'h0, !mPd && mLocked});
    check("R7", "wordValid vs model", {27'h0, wordValid}, {27'h0, !mPd && mValid});
    check("R8", "wordClk vs model", {27'h0, wordClk}, {27'h0, expClk});
    if (wordClk) clkHighCnt++;
  endtask

  task automatic stepSlot(input logic [27:0] w, input logic [6:0] pat, input int j, input bit pd);
    logic [3:0] ln;
    @(negedge bitClk);
    compareAll();
    for (int k = 0; k < 4; k++) ln[k] = w[7*k+j];
    laneIn = ln;
    clkLaneIn = pat[6-j];
    powerDown = pd;
    modelStep(pd, ln, pat[6-j]);
  endtask

  task automatic sendSlots(input logic [27:0] w, input logic [6:0] pat, input int from, input int upto);
    for (int j = from; j <= upto; j++) stepSlot(w, pat, j, 1'b0);
  endtask

  task automatic sendWord(input logic [27:0] w, input logic [6:0] pat);
    sendSlots(w, pat, 0, 6);
  endtask

  task automatic afterEdge();
    @(posedge bitClk);
    #2;
  endtask

  initial begin
    repeat (100000) @(posedge bitClk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge bitClk);
    // R1: reset state
    check("R1", "wordOut in reset", wordOut, 28'h0);
    check("R1", "locked in reset", {27'h0, locked}, 28'h0);
    check("R1", "wordClk in reset", {27'h0, wordClk}, 28'h0);
    check("R1", "wordValid in reset", {27'h0, wordValid}, 28'h0);
    rstN = 1'b1;
    for (int j = 0; j < 3; j++) stepSlot(28'h0, 7'b0, j, 1'b0);

    // three framed words; lock not yet reached (R9)
    sendWord(28'hA5C3F01, MARK);
    sendWord(28'h5E1B2C7, MARK);
    sendWord(28'h0F0F0F0, MARK);
    afterEdge();
    check("R9", "word before lock", wordOut, 28'h0);
    check("R9", "locked before lock", {27'h0, locked}, 28'h0);

    // third boundary acted on: lock, second word published (R4, R6, R7)
    stepSlot(28'h1234567, MARK, 0, 1'b0);
    afterEdge();
    check("R4", "locked after third boundary", {27'h0, locked}, 28'h1);
    check("R6", "published word is the second sent", wordOut, 28'h5E1B2C7);
    check("R7", "valid pulse at publish", {27'h0, wordValid}, 28'h1);

    // R8: seven samples, four high
    clkHighCnt = 0;
    sendSlots(28'h1234567, MARK, 1, 6);
    stepSlot(28'h7654321, MARK, 0, 1'b0);
    check("R8", "wordClk high count per word", 28'(clkHighCnt), 28'd4);
    sendSlots(28'h7654321, MARK, 1, 6);

    // R3: single-bit words land at 7k+j
    sendWord(28'h1 << 19, MARK);
    sendWord(28'h1 << 21, MARK);
    stepSlot(28'h0000001, MARK, 0, 1'b0);
    afterEdge();
    check("R3", "lane2 slot5 -> bit19", wordOut, 28'h1 << 19);
    sendSlots(28'h0000001, MARK, 1, 6);
    stepSlot(28'hFFFFFFF, MARK, 0, 1'b0);
    afterEdge();
    check("R3", "lane3 slot0 -> bit21", wordOut, 28'h1 << 21);
    sendSlots(28'hFFFFFFF, MARK, 1, 6);

    // R5: damaged mark drops lock
    sendWord(28'h3333333, BAD);
    stepSlot(28'h4444444, MARK, 0, 1'b0);
    afterEdge();
    check("R5", "locked after bad mark", {27'h0, locked}, 28'h0);
    check("R5", "word after bad mark", wordOut, 28'h0);
    sendSlots(28'h4444444, MARK, 1, 6);
    sendWord(28'h5555555, MARK);
    sendWord(28'h6666666, MARK);
    stepSlot(28'h0ABCDEF, MARK, 0, 1'b0);
    afterEdge();
    check("R2", "relock after three good marks", {27'h0, locked}, 28'h1);
    sendSlots(28'h0ABCDEF, MARK, 1, 6);

    // R5: one-slot slip drops lock
    stepSlot(28'h0, 7'b0, 0, 1'b0);
    sendWord(28'h1111111, MARK);
    afterEdge();
    check("R5", "locked after slip", {27'h0, locked}, 28'h0);
    sendWord(28'h2222222, MARK);
    sendWord(28'h3C3C3C3, MARK);
    stepSlot(28'h0C0FFEE, MARK, 0, 1'b0);
    afterEdge();
    check("R5", "relock after slip", {27'h0, locked}, 28'h1);
    check("R6", "word after slip relock", wordOut, 28'h2222222);
    sendSlots(28'h0C0FFEE, MARK, 1, 6);

    // R10: power-down while locked
    stepSlot(28'h0, MARK, 0, 1'b1);
    #1;
    check("R10", "wordOut in power-down", wordOut, 28'h0);
    check("R10", "locked in power-down", {27'h0, locked}, 28'h0);
    check("R10", "wordClk in power-down", {27'h0, wordClk}, 28'h0);
    for (int j = 1; j < 5; j++) stepSlot(28'hFFFFFFF, MARK, j, 1'b1);
    sendWord(28'h0123456, MARK);
    sendWord(28'h0654321, MARK);
    stepSlot(28'h0DDDDDD, MARK, 0, 1'b0);
    afterEdge();
    check("R10", "no lock after two marks", {27'h0, locked}, 28'h0);
    sendSlots(28'h0DDDDDD, MARK, 1, 6);
    stepSlot(28'h0EEEEEE, MARK, 0, 1'b0);
    afterEdge();
    check("R10", "lock after three marks", {27'h0, locked}, 28'h1);
    check("R6", "word after power-down relock", wordOut, 28'h0654321);
    sendSlots(28'h0EEEEEE, MARK, 1, 6);
    stepSlot(28'h0, MARK, 0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule